// File: doc/BRIEF.md
# Receive Packet Address and Length Gate

This block sits between a packet source and a receive buffer. Bytes of one packet arrive on a strobed byte stream. The first byte carries a start marker and the last byte carries an end marker. The packet's total size is presented with the first byte. As the bytes arrive they are staged in a shadow store. Once the end marker has been seen, the block checks the destination address and the length against the configuration ports. It commits the packet to the visible buffer only when both checks pass.

The destination is the byte at index 1. The address-check mode selects one of four acceptance rules, and the length mode selects a variable (upper bound) or fixed (exact) policy. On commit, the buffer contents are replaced, the byte count is published, the read pointer returns to the first byte, and a one-cycle receive interrupt is raised. A packet that fails any check changes neither the buffer contents nor the byte count. An unsupported length mode raises an error pulse, and a packet larger than the buffer raises an overflow pulse.

Top module: `rx_pkt_gate`

## Requirements
- R1: After reset, rx_count is 0, rd_data is 0x00, and rx_irq, overflow and len_mode_err are all low.
- R2: With addr_mode 2'b00, a packet passes the address check whatever its destination byte (index 1).
- R3: With addr_mode 2'b01, only a destination equal to own_addr passes. A packet that fails leaves rx_count and the stored bytes as they were.
- R4: With addr_mode 2'b10, a destination equal to own_addr or to 0x00 passes, and 0xFF fails.
- R5: With addr_mode 2'b11, a destination equal to own_addr, 0x00 or 0xFF passes. Any other destination fails.
- R6: With len_mode 2'b01, a packet passes the length check when in_size <= len_limit and fails when in_size > len_limit.
- R7: With len_mode 2'b00, a packet passes the length check only when in_size == len_limit.
- R8: With len_mode 2'b10 or 2'b11, the packet is dropped and len_mode_err is high for exactly one cycle.
- R9: For an accepted packet, rx_irq is high for exactly one cycle, two clock edges after the edge that takes the end byte. In that same cycle, rx_count first shows in_size, and rd_data shows byte 0.
- R10: A packet with in_size greater than 64 (DEPTH) is dropped and overflow is high for exactly one cycle. A packet of exactly 64 bytes is stored.
- R11: Each clock edge with rd_en high advances the read pointer by one byte while stored bytes remain, so the bytes come out in arrival order. Once all bytes have been read, rd_data is 0x00 and further rd_en has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet byte is present on in_data |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_eop | input | 1 | Marks the last byte of a packet |
| in_data | input | 8 | Packet byte |
| in_size | input | SZW | Total packet size in bytes, sampled with the first byte |
| addr_mode | input | 2 | Address acceptance rule |
| own_addr | input | 8 | Address of this node |
| len_mode | input | 2 | 00 fixed, 01 variable, others unsupported |
| len_limit | input | SZW | Exact length (fixed) or maximum length (variable) |
| rd_en | input | 1 | Advance the read pointer by one byte |
| rd_data | output | 8 | Byte at the read pointer, 0x00 when none remain |
| rx_count | output | CW | Size of the stored packet |
| rx_irq | output | 1 | One-cycle pulse when a packet is stored |
| overflow | output | 1 | One-cycle pulse when a packet exceeds the buffer |
| len_mode_err | output | 1 | One-cycle pulse when len_mode is unsupported |

## Verification
The properties assume a well-formed input stream. Each packet begins with a start-marked byte, carries exactly one end-marked byte, and is followed by at least two idle cycles before the next start. in_size and the configuration ports are also assumed to match the packet while it is being judged. The stimulus meets these assumptions as follows. A single driver task emits every packet on consecutive cycles and leaves three idle cycles after each one. The configuration is changed only between packets, and in_size is always the true length. The bench rejects some packets and accepts others, and reads the buffer after a rejected packet, so that untouched contents are observed at the read port.

// File: rtl/rx_pkt_gate.sv
module rx_pkt_gate #(
  parameter int DEPTH = 64,
  parameter int SZW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_sop,
  input  logic           in_eop,
  input  logic [7:0]     in_data,
  input  logic [SZW-1:0] in_size,
  input  logic [1:0]     addr_mode,
  input  logic [7:0]     own_addr,
  input  logic [1:0]     len_mode,
  input  logic [SZW-1:0] len_limit,
  input  logic           rd_en,
  output logic [7:0]     rd_data,
  output logic [CW-1:0]  rx_count,
  output logic           rx_irq,
  output logic           overflow,
  output logic           len_mode_err
);

  logic [7:0]     shadow [DEPTH];
  logic [7:0]     store  [DEPTH];
  logic [CW-1:0]  wr_idx, rd_idx, cur_idx;
  logic [SZW-1:0] size_q;
  logic [7:0]     dest_q;
  logic           dest_seen, judge;
  logic           addr_ok, len_ok, too_big, accept;

  assign cur_idx = in_sop ? '0 : wr_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx    <= '0;
      size_q    <= '0;
      dest_q    <= '0;
      dest_seen <= 1'b0;
      judge     <= 1'b0;
    end else begin
      judge <= in_valid & in_eop;
      if (in_valid) begin
        if (in_sop) begin
          size_q    <= in_size;
          dest_seen <= 1'b0;
        end
        if (cur_idx == CW'(1)) begin
          dest_q    <= in_data;
          dest_seen <= 1'b1;
        end
        if (cur_idx < CW'(DEPTH)) wr_idx <= cur_idx + 1'b1;
        else wr_idx <= cur_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && cur_idx < CW'(DEPTH)) shadow[cur_idx[AW-1:0]] <= in_data;
  end

  assign addr_ok = (addr_mode == 2'b00) |
                   (dest_seen & ((dest_q == own_addr) |
                                 (addr_mode == 2'b10 & dest_q == 8'h00) |
                                 (addr_mode == 2'b11 & (dest_q == 8'h00 | dest_q == 8'hFF))));
  assign len_ok  = (len_mode == 2'b01) ? (size_q <= len_limit) :
                   (len_mode == 2'b00) ? (size_q == len_limit) : 1'b0;
  assign too_big = size_q > SZW'(DEPTH);
  assign accept  = judge & addr_ok & len_ok & ~too_big;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_count     <= '0;
      rd_idx       <= '0;
      rx_irq       <= 1'b0;
      overflow     <= 1'b0;
      len_mode_err <= 1'b0;
    end else begin
      rx_irq       <= accept;
      overflow     <= judge & too_big;
      len_mode_err <= judge & len_mode[1];
      if (accept) begin
        rx_count <= size_q[CW-1:0];
        rd_idx   <= '0;
      end else if (rd_en && rd_idx < rx_count) begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= shadow[i];
    end
  end

  assign rd_data = (rd_idx < rx_count) ? store[rd_idx[AW-1:0]] : 8'h00;

endmodule

module rx_pkt_gate_props #(
  parameter int CW = 7,
  parameter int DEPTH = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_eop,
  input logic          rx_irq,
  input logic          overflow,
  input logic          len_mode_err,
  input logic [CW-1:0] rx_count
);

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  assert_irq_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(in_valid && in_eop, 2));

  assert_count_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq |-> $stable(rx_count));

  assert_no_store_on_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !rx_irq);

  assert_no_store_on_bad_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    len_mode_err |-> !rx_irq);

  assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    len_mode_err |=> !len_mode_err);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

endmodule

bind rx_pkt_gate rx_pkt_gate_props #(.CW(CW), .DEPTH(DEPTH)) u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
  .rx_irq(rx_irq), .overflow(overflow), .len_mode_err(len_mode_err),
  .rx_count(rx_count)
);

// File: tb/rx_pkt_gate_test.sv
module rx_pkt_gate_test;
  localparam int DEPTH = 64;
  localparam int CW = 7;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0] in_data = 0, in_size = 0;
  logic [1:0] addr_mode = 0, len_mode = 1;
  logic [7:0] own_addr = 8'h12, len_limit = 8'd60;
  logic rd_en = 0;
  logic [7:0] rd_data;
  logic [CW-1:0] rx_count;
  logic rx_irq, overflow, len_mode_err;

  always #2.5 clk = ~clk;

  rx_pkt_gate uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .in_size(in_size), .addr_mode(addr_mode), .own_addr(own_addr),
    .len_mode(len_mode), .len_limit(len_limit), .rd_en(rd_en), .rd_data(rd_data),
    .rx_count(rx_count), .rx_irq(rx_irq), .overflow(overflow), .len_mode_err(len_mode_err)
  );

  typedef struct {
    string tag;
    bit irq, ovf, lerr;
    int count;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  bit done = 0;
  byte unsigned model_mem [DEPTH];
  int model_count = 0, model_rd = 0;

  function automatic byte unsigned pbyte(int i, byte unsigned dest, int seed);
    return (i == 1) ? dest : 8'((seed * 7 + i * 13 + 3) & 8'hFF);
  endfunction

  function automatic bit addr_pass(int n, byte unsigned dest);
    if (addr_mode == 2'b00) return 1;
    if (n < 2) return 0;
    return (dest == own_addr) || (addr_mode == 2'b10 && dest == 8'h00) ||
           (addr_mode == 2'b11 && (dest == 8'h00 || dest == 8'hFF));
  endfunction

  function automatic bit len_pass(int n);
    if (len_mode == 2'b01) return n <= int'(len_limit);
    if (len_mode == 2'b00) return n == int'(len_limit);
    return 0;
  endfunction

  task automatic check(string tag, bit ok, string detail);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, detail);
    end
  endtask

  task automatic send(string tag, int n, byte unsigned dest, int seed);
    exp_t e;
    bit acc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_eop = (i == n - 1);
      in_data = pbyte(i, dest, seed); in_size = 8'(n);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
    acc = addr_pass(n, dest) && len_pass(n) && n <= DEPTH;
    e.tag = tag; e.irq = acc; e.ovf = (n > DEPTH); e.lerr = len_mode[1];
    if (acc) begin
      for (int i = 0; i < n; i++) model_mem[i] = pbyte(i, dest, seed);
      model_count = n; model_rd = 0;
    end
    e.count = model_count;
    q.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_bytes(string tag, int k);
    for (int i = 0; i < k; i++) begin
      int expv;
      @(negedge clk);
      expv = (model_rd < model_count) ? int'(model_mem[model_rd]) : 0;
      check(tag, rd_data == 8'(expv),
            $sformatf("read %0d: actual=%02h expected=%02h", i, rd_data, expv));
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      if (model_rd < model_count) model_rd++;
    end
  endtask

  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      @(negedge clk);
      check(e.tag, rx_irq == e.irq && overflow == e.ovf && len_mode_err == e.lerr &&
                   int'(rx_count) == e.count,
            $sformatf("actual irq=%0b ovf=%0b lerr=%0b count=%0d expected irq=%0b ovf=%0b lerr=%0b count=%0d",
                      rx_irq, overflow, len_mode_err, rx_count, e.irq, e.ovf, e.lerr, e.count));
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", rx_count == 0 && rd_data == 0 && !rx_irq && !overflow && !len_mode_err,
          $sformatf("actual count=%0d data=%02h irq=%0b ovf=%0b lerr=%0b expected all zero",
                    rx_count, rd_data, rx_irq, overflow, len_mode_err));
    rst_n = 1;
    @(negedge clk);

    addr_mode = 2'b00; len_mode = 2'b01; len_limit = 60;
    send("R2", 10, 8'h55, 1);
    read_bytes("R11", 12);
    send("R2", 6, 8'hFF, 2);

    addr_mode = 2'b01;
    send("R3", 8, 8'h12, 3);
    send("R3", 5, 8'h00, 4);
    send("R3", 5, 8'h13, 5);
    read_bytes("R3", 9);

    addr_mode = 2'b10;
    send("R4", 7, 8'h00, 6);
    send("R4", 7, 8'hFF, 7);
    read_bytes("R4", 3);
    send("R4", 9, 8'h12, 8);

    addr_mode = 2'b11;
    send("R5", 4, 8'hFF, 9);
    send("R5", 5, 8'h00, 10);
    send("R5", 6, 8'h33, 11);
    read_bytes("R5", 6);

    addr_mode = 2'b00; len_mode = 2'b01; len_limit = 20;
    send("R6", 20, 8'h01, 12);
    send("R6", 21, 8'h01, 13);
    read_bytes("R6", 2);

    len_mode = 2'b00; len_limit = 12;
    send("R7", 12, 8'h02, 14);
    send("R7", 11, 8'h02, 15);
    send("R7", 13, 8'h02, 16);
    read_bytes("R7", 13);

    len_mode = 2'b10;
    send("R8", 12, 8'h03, 17);
    len_mode = 2'b11;
    send("R8", 12, 8'h03, 18);

    len_mode = 2'b01; len_limit = 8'd255;
    send("R10", 64, 8'h04, 19);
    send("R10", 65, 8'h04, 20);
    read_bytes("R10", 65);
    send("R9", 3, 8'h05, 21);
    read_bytes("R9", 4);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule